// File: doc/BRIEF.md
# Target-Side Data-Phase REQ/ACK Handshake Engine

This block runs the byte handshake of a parallel 8-bit SCSI bus data phase from the target side. It runs from a 96 MHz clock. A transfer length is presented as two bytes and takes effect only when a separate load strobe is pulsed. The engine then issues one REQ per byte and counts the initiator's ACKs until every byte has been handshaked. After that it raises a completion flag. In an output phase it takes bytes from a valid/ready stream and drives them onto the bus. In an input phase it captures the bus byte on each ACK rising edge and presents it as a one-cycle valid pulse.

The configuration registers inside the block set the timing, all in clock counts:

- a deskew count, which is the setup time from data to REQ;
- a REQ assertion count;
- a data hold count.

A sync-offset register selects the handshake mode:

- **Offset zero:** fully interlocked asynchronous handshake.
- **Nonzero offset:** synchronous handshake, in which at most that many REQs may be outstanding without their ACKs.

A bus reset input aborts any transfer at once. Phase changes are refused while either handshake line is asserted.

Top module: `scsi_req_ack_timer`

## Requirements
- R1: After chip reset, deskew is 6, hold is 5, assertion is 8 and sync offset is 0. REQ is low, the completion flag is low, and the phase output is 0.
- R2: Configuration write fields: the assertion count is cfg_timing[3:0], the hold count is cfg_timing[6:4] and the deskew count is cfg_deskew. In synchronous mode each REQ is high for exactly max(assertion,1) clocks.
- R3: In an output phase, db_o changes exactly deskew clocks before REQ rises. db_o stays stable while REQ is high and for at least hold clocks after REQ falls.
- R4: With offset 0, REQ rises only while ACK is low, and falls only after ACK has been seen high. The next REQ waits for ACK to go low again.
- R5: With a nonzero offset, REQs outstanding (REQ rises minus ACK rising edges) never exceed the offset. When ACKs are withheld, exactly offset REQs are issued and the engine then stalls.
- R6: The length {len_hi,len_lo} takes effect only on a len_load pulse. Exactly that many REQs are then issued.
- R7: done_o goes high once as many ACK rising edges as the loaded length have been seen, with REQ low. It is high one clock after loading a length of zero, and low one clock after loading a nonzero length.
- R8: A phase write (phase_d to bus_phase) is ignored while REQ or ACK is high. bus_phase[0]=1 means the target drives data, and db_oe follows bus_phase[0].
- R9: In an input phase (bus_phase[0]=0), db_i is captured on each ACK rising edge and output on rx_data with a one-clock rx_valid pulse, in order.
- R10: bus_rst drops REQ and clears the remaining count, the outstanding-REQ counter and done_o in the next clock. A following transfer gets the full offset again.
- R11: In an output phase, a byte is taken (tx_ready with tx_valid) once per REQ, in stream order. No REQ is issued while tx_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 96 MHz clock |
| rst_n | input | 1 | Active-low chip reset, restores default timing |
| bus_rst | input | 1 | Bus reset, aborts the transfer |
| cfg_we | input | 1 | Writes the three timing/offset registers |
| cfg_deskew | input | 3 | Deskew count |
| cfg_timing | input | 7 | [6:4] hold count, [3:0] assertion count |
| cfg_offset | input | OFF_W | Sync offset, 0 = asynchronous |
| phase_we | input | 1 | Phase register write |
| phase_d | input | 3 | New phase, bit 0 = target drives data |
| len_hi | input | 8 | Transfer length high byte |
| len_lo | input | 8 | Transfer length low byte |
| len_load | input | 1 | Starts a transfer with the presented length |
| tx_data | input | DW | Outgoing byte stream data |
| tx_valid | input | 1 | Outgoing byte available |
| tx_ready | output | 1 | Byte taken this clock |
| rx_data | output | DW | Captured incoming byte |
| rx_valid | output | 1 | One-clock pulse per captured byte |
| ack_i | input | 1 | ACK from the initiator, active high |
| db_i | input | DW | Data bus as seen by the receiver |
| db_o | output | DW | Data bus drive value |
| db_oe | output | 1 | Data bus drive enable |
| bus_phase | output | 3 | Phase lines driven to the bus |
| req_o | output | 1 | REQ, active high |
| done_o | output | 1 | All programmed bytes handshaked |

## Verification
The bench goes after these corner cases:

- **Offset cap with ACKs withheld.** A design that miscounts ACK edges would issue one REQ too many or stall one short.
- **Bus reset with REQs outstanding.** A design that keeps the stale counter would issue no REQs on the next transfer.
- **Slow ACK in interlocked mode.** A design that times REQ out would drop it before ACK arrives.
- **Phase write landing mid-REQ.** A design without the guard would flip the drive direction under an active handshake.

It also measures deskew, REQ width and hold under three timing profiles. It checks zero-length and strobe-less length writes. It checks a stalled byte stream, which would otherwise make the design drive stale data.

// File: rtl/scsi_req_ack_timer.sv
module scsi_req_ack_timer #(
  parameter int         DW         = 8,
  parameter int         OFF_W      = 4,
  parameter logic [2:0] RST_DESKEW = 3'd6,
  parameter logic [2:0] RST_HOLD   = 3'd5,
  parameter logic [3:0] RST_ASSERT = 4'd8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_deskew,
  input  logic [6:0]       cfg_timing,
  input  logic [OFF_W-1:0] cfg_offset,
  input  logic             phase_we,
  input  logic [2:0]       phase_d,
  input  logic [7:0]       len_hi,
  input  logic [7:0]       len_lo,
  input  logic             len_load,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  input  logic             ack_i,
  input  logic [DW-1:0]    db_i,
  output logic [DW-1:0]    db_o,
  output logic             db_oe,
  output logic [2:0]       bus_phase,
  output logic             req_o,
  output logic             done_o
);

  localparam int LEN_W = 16;
  localparam logic [OFF_W-1:0] ONE_O = OFF_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_SKEW, S_REQ, S_HOLD, S_REL} st_t;

  st_t              st;
  logic [3:0]       tmr;
  logic [2:0]       deskew_q, hold_q, phase_q;
  logic [3:0]       asrt_q;
  logic [OFF_W-1:0] off_q, outst;
  logic [LEN_W-1:0] req_left, ack_left;
  logic             loaded, req_q, ack_q;
  logic [DW-1:0]    db_q;

  logic io, async_m, ack_rise, ack_dec, slot_ok, go, req_rise;
  logic [3:0] asrt_ld, skew_ld;

  assign io       = phase_q[0];
  assign async_m  = (off_q == '0);
  assign ack_rise = ack_i & ~ack_q;
  assign ack_dec  = ack_rise & (outst != '0);
  assign slot_ok  = async_m ? ~ack_i : (outst < off_q);
  assign go       = (st == S_IDLE) & (req_left != '0) & slot_ok & (~io | tx_valid)
                    & ~bus_rst & ~len_load;
  assign asrt_ld  = (asrt_q == '0) ? '0 : asrt_q - 4'd1;
  assign skew_ld  = {1'b0, deskew_q} - 4'd1;
  assign req_rise = (go & (~io | (deskew_q == '0))) | ((st == S_SKEW) & (tmr == '0));

  assign tx_ready  = go & io;
  assign db_o      = db_q;
  assign db_oe     = io;
  assign bus_phase = phase_q;
  assign req_o     = req_q;
  assign done_o    = loaded & (ack_left == '0) & (st == S_IDLE) & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deskew_q <= RST_DESKEW;
      hold_q   <= RST_HOLD;
      asrt_q   <= RST_ASSERT;
      off_q    <= '0;
      phase_q  <= '0;
      st       <= S_IDLE;
      tmr      <= '0;
      outst    <= '0;
      req_left <= '0;
      ack_left <= '0;
      loaded   <= 1'b0;
      req_q    <= 1'b0;
      ack_q    <= 1'b0;
      db_q     <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      ack_q    <= ack_i;
      rx_valid <= 1'b0;
      if (cfg_we) begin
        deskew_q <= cfg_deskew;
        hold_q   <= cfg_timing[6:4];
        asrt_q   <= cfg_timing[3:0];
        off_q    <= cfg_offset;
      end
      if (phase_we && !req_q && !ack_i) phase_q <= phase_d;

      if (bus_rst) begin
        st       <= S_IDLE;
        req_q    <= 1'b0;
        outst    <= '0;
        req_left <= '0;
        ack_left <= '0;
        loaded   <= 1'b0;
      end else begin
        if (len_load) begin
          req_left <= {len_hi, len_lo};
          ack_left <= {len_hi, len_lo};
          loaded   <= 1'b1;
        end else begin
          if (go) req_left <= req_left - 16'd1;
          if (ack_rise && ack_left != '0) begin
            ack_left <= ack_left - 16'd1;
            if (!io) begin
              rx_valid <= 1'b1;
              rx_data  <= db_i;
            end
          end
        end

        case ({req_rise, ack_dec})
          2'b10:   outst <= outst + ONE_O;
          2'b01:   outst <= outst - ONE_O;
          default: outst <= outst;
        endcase

        case (st)
          S_IDLE: if (go) begin
            if (io) db_q <= tx_data;
            if (io && deskew_q != '0) begin
              st  <= S_SKEW;
              tmr <= skew_ld;
            end else begin
              req_q <= 1'b1;
              st    <= S_REQ;
              tmr   <= asrt_ld;
            end
          end
          S_SKEW: if (tmr == '0) begin
            req_q <= 1'b1;
            st    <= S_REQ;
            tmr   <= asrt_ld;
          end else tmr <= tmr - 4'd1;
          S_REQ: if (tmr != '0) tmr <= tmr - 4'd1;
          else if (!async_m || ack_i) begin
            req_q <= 1'b0;
            st    <= S_HOLD;
            tmr   <= {1'b0, hold_q};
          end
          S_HOLD: if (tmr == '0) st <= async_m ? S_REL : S_IDLE;
          else tmr <= tmr - 4'd1;
          S_REL: if (!ack_i) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R5
  offset_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_o) && $past(off_q) != '0) |-> ($past(outst) < $past(off_q)))
    else $error("REQ issued with offset window full");

  // R4
  interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_o) && $past(off_q) == '0) |-> !$past(ack_i))
    else $error("async REQ rose while ACK high");

  // R10
  bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (!req_o && !done_o && outst == '0))
    else $error("bus reset did not abort");

  // R8
  phase_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o || ack_i) |=> $stable(bus_phase))
    else $error("phase moved during handshake");

  // R3
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && $past(req_o)) |-> $stable(db_o))
    else $error("data moved while REQ high");

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!req_o && !tx_ready))
    else $error("done while handshaking");

endmodule

// File: tb/tb_scsi_req_ack_timer.sv
`timescale 1ns/1ps
module tb_scsi_req_ack_timer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bus_rst, cfg_we, phase_we, len_load, tx_ready, rx_valid, db_oe, req_o, done_o;
  logic [2:0] cfg_deskew, phase_d, bus_phase;
  logic [6:0] cfg_timing;
  logic [3:0] cfg_offset;
  logic [7:0] len_hi, len_lo, tx_data, rx_data, db_o;
  logic       tx_valid;
  logic       ack_i = 1'b0;
  logic [7:0] db_i = 8'h00;

  scsi_req_ack_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
    .cfg_we(cfg_we), .cfg_deskew(cfg_deskew), .cfg_timing(cfg_timing), .cfg_offset(cfg_offset),
    .phase_we(phase_we), .phase_d(phase_d),
    .len_hi(len_hi), .len_lo(len_lo), .len_load(len_load),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .ack_i(ack_i), .db_i(db_i),
    .db_o(db_o), .db_oe(db_oe), .bus_phase(bus_phase), .req_o(req_o), .done_o(done_o)
  );

  // byte stream source
  logic [7:0] src [0:63];
  int nsrc = 0;
  int idx = 0;
  logic flush = 1'b0;
  assign tx_valid = (idx < nsrc);
  assign tx_data  = src[idx[5:0]];
  always @(posedge clk) begin
    if (flush) idx <= nsrc;
    else if (tx_valid && tx_ready) idx <= idx + 1;
  end

  // scoreboard and initiator model
  logic [7:0] exp_q[$];
  logic [7:0] rx_exp[$];
  int mon_err = 0, mon_chk = 0;
  int req_cnt = 0, ack_cnt = 0, rx_cnt = 0, pend = 0, hi_cnt = 0;
  int w = 0, db_age = 1000, since_fall = 1000;
  logic req_prev = 1'b0;
  logic [7:0] db_prev = 8'h00;
  logic [7:0] in_val = 8'h60;
  logic clr = 1'b0, resp_sync = 1'b0, ack_block = 1'b0;
  int ack_delay = 1;
  int cur_deskew = 6, cur_hold = 5, cur_assert = 8;
  logic cur_sync = 1'b0;

  task automatic mchk(input logic ok, input string r, input int act, input int expv);
    mon_chk++;
    if (!ok) begin
      mon_err++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, expv);
    end
  endtask

  always @(negedge clk) begin
    logic rise, fall;
    int wexp;
    logic [7:0] e;
    if (clr) begin
      req_cnt = 0; ack_cnt = 0; rx_cnt = 0; pend = 0; hi_cnt = 0;
      exp_q.delete();
    end
    rise = req_o && !req_prev;
    fall = !req_o && req_prev;
    if (fall) since_fall = 0;
    else if (since_fall < 1000) since_fall++;
    if (db_o != db_prev) begin
      // R3 hold after REQ falls
      if (db_oe && since_fall < 1000) mchk(since_fall >= cur_hold, "R3 hold", since_fall, cur_hold);
      db_age = 0;
    end else if (db_age < 1000) db_age++;
    if (rise) begin
      req_cnt++;
      w = 0;
      if (db_oe) begin
        // R11 byte order / R3 deskew
        if (exp_q.size() == 0) mchk(1'b0, "R11 unexpected REQ", db_o, -1);
        else begin
          e = exp_q.pop_front();
          mchk(db_o == e, "R11 data", db_o, e);
        end
        mchk(db_age == cur_deskew, "R3 deskew", db_age, cur_deskew);
      end
      if (!cur_sync) mchk(!ack_i, "R4 REQ rose with ACK high", ack_i, 0);
    end
    if (req_o) w++;
    if (fall) begin
      wexp = (cur_assert == 0) ? 1 : cur_assert;
      // R2 assertion width
      if (cur_sync || ack_delay == 1) mchk(w == wexp, "R2 REQ width", w, wexp);
      else mchk(w >= wexp, "R2 REQ min width", w, wexp);
      if (!cur_sync) mchk(ack_i, "R4 REQ fell before ACK", ack_i, 1);
    end
    if (rx_valid) begin
      rx_cnt++;
      if (rx_exp.size() == 0) mchk(1'b0, "R9 unexpected rx", rx_data, -1);
      else begin
        e = rx_exp.pop_front();
        mchk(rx_data == e, "R9 rx data", rx_data, e);
      end
    end
    if (resp_sync) begin
      if (rise) pend++;
      if (ack_i) ack_i = 1'b0;
      else if (!ack_block && pend > 0) begin
        pend--;
        ack_i = 1'b1; ack_cnt++;
        if (!db_oe) begin db_i = in_val; rx_exp.push_back(in_val); in_val++; end
      end
    end else begin
      if (req_o) begin
        hi_cnt++;
        if (hi_cnt >= ack_delay && !ack_i) begin
          ack_i = 1'b1; ack_cnt++;
          if (!db_oe) begin db_i = in_val; rx_exp.push_back(in_val); in_val++; end
        end
      end else begin
        hi_cnt = 0;
        ack_i = 1'b0;
      end
    end
    req_prev = req_o;
    db_prev = db_o;
  end

  int err = 0, nchk = 0;
  logic [7:0] next_b = 8'h11;

  task automatic chk(input logic ok, input string r, input int act, input int expv);
    nchk++;
    if (!ok) begin
      err++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, expv);
    end
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      src[nsrc[5:0]] = next_b;
      exp_q.push_back(next_b);
      nsrc++;
      next_b++;
    end
  endtask

  task automatic load(input int n);
    @(negedge clk);
    len_hi = n[15:8]; len_lo = n[7:0]; len_load = 1'b1;
    @(negedge clk);
    len_load = 1'b0;
  endtask

  task automatic set_phase(input logic [2:0] p);
    @(negedge clk);
    phase_d = p; phase_we = 1'b1;
    @(negedge clk);
    phase_we = 1'b0;
  endtask

  task automatic cfg(input int d, input int h, input int a, input int off);
    @(negedge clk);
    cfg_deskew = d[2:0]; cfg_timing = {h[2:0], a[3:0]}; cfg_offset = off[3:0]; cfg_we = 1'b1;
    cur_deskew = d; cur_hold = h; cur_assert = a; cur_sync = (off != 0);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(input string r);
    int n = 0;
    @(negedge clk);
    while (!done_o && n < 4000) begin @(negedge clk); n++; end
    chk(done_o, r, done_o, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr <= 1'b1; flush <= 1'b1;
    @(negedge clk);
    clr <= 1'b0; flush <= 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_deskew = 6; cur_hold = 5; cur_assert = 8; cur_sync = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_tests();
    do_reset();
    // R1 reset state
    chk(req_o == 1'b0, "R1 req after reset", req_o, 0);
    chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
    chk(bus_phase == 3'd0, "R1 phase after reset", bus_phase, 0);

    // R1/R3/R11 default profile, async output
    set_phase(3'b001);
    chk(db_oe == 1'b1, "R8 drive enable in output phase", db_oe, 1);
    push_n(3);
    load(3);
    chk(done_o == 1'b0, "R7 done low after load", done_o, 0);
    wait_done("R7 done after 3 bytes");
    chk(req_cnt == 3, "R6 REQ count", req_cnt, 3);
    chk(ack_cnt == 3, "R7 ACK count", ack_cnt, 3);
    chk(exp_q.size() == 0, "R11 all bytes sent", exp_q.size(), 0);

    // R6 length without strobe has no effect
    push_n(2);
    @(negedge clk);
    len_hi = 8'h00; len_lo = 8'h05;
    repeat (30) @(negedge clk);
    chk(req_cnt == 3, "R6 no REQ without strobe", req_cnt, 3);
    chk(done_o == 1'b1, "R6 done kept without strobe", done_o, 1);
    load(2);
    chk(done_o == 1'b0, "R7 done cleared by load", done_o, 0);
    wait_done("R7 done after 2 bytes");
    chk(req_cnt == 5, "R6 REQ count second", req_cnt, 5);

    // R11 stalled stream, then R7 zero length
    load(3);
    repeat (30) @(negedge clk);
    chk(req_cnt == 5, "R11 no REQ without tx_valid", req_cnt, 5);
    chk(done_o == 1'b0, "R11 not done while stalled", done_o, 0);
    load(0);
    chk(done_o == 1'b1, "R7 done after zero length", done_o, 1);

    // R4/R8 slow ACK, phase write during REQ
    ack_delay = 15;
    push_n(2);
    load(2);
    while (!req_o) @(negedge clk);
    phase_d = 3'b000; phase_we = 1'b1;
    @(negedge clk);
    phase_we = 1'b0;
    chk(bus_phase == 3'b001, "R8 phase write ignored during REQ", bus_phase, 1);
    wait_done("R4 slow ACK transfer done");
    ack_delay = 1;
    set_phase(3'b000);
    chk(bus_phase == 3'b000 && db_oe == 1'b0, "R8 phase write when idle", bus_phase, 0);

    // R9 async input
    pulse_clr();
    load(3);
    wait_done("R9 async input done");
    chk(rx_cnt == 3, "R9 rx count async", rx_cnt, 3);
    chk(rx_exp.size() == 0, "R9 rx queue empty", rx_exp.size(), 0);

    // R5/R2 sync 20 MB/s profile, ACKs withheld
    cfg(2, 2, 2, 4);
    set_phase(3'b001);
    resp_sync <= 1'b1; ack_block <= 1'b1;
    pulse_clr();
    push_n(8);
    load(8);
    repeat (60) @(negedge clk);
    chk(req_cnt == 4, "R5 REQs capped at offset", req_cnt, 4);
    chk(done_o == 1'b0, "R5 not done while capped", done_o, 0);
    ack_block <= 1'b0;
    wait_done("R5 sync done");
    chk(req_cnt == 8, "R5 all REQs after release", req_cnt, 8);

    // R9/R2 sync 10 MB/s input, offset 2
    cfg(3, 3, 3, 2);
    set_phase(3'b000);
    pulse_clr();
    load(5);
    wait_done("R9 sync input done");
    chk(rx_cnt == 5, "R9 rx count sync", rx_cnt, 5);

    // R2 custom field split
    cfg(1, 1, 5, 3);
    set_phase(3'b001);
    pulse_clr();
    push_n(4);
    load(4);
    wait_done("R2 custom profile done");

    // R10 bus reset with REQs outstanding
    ack_block <= 1'b1;
    pulse_clr();
    push_n(6);
    load(6);
    repeat (40) @(negedge clk);
    chk(req_cnt == 3, "R5 REQs capped before bus reset", req_cnt, 3);
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    chk(req_o == 1'b0 && done_o == 1'b0, "R10 abort", {req_o, done_o}, 0);
    pulse_clr();
    push_n(2);
    load(2);
    repeat (40) @(negedge clk);
    chk(req_cnt == 2, "R10 window restored", req_cnt, 2);
    ack_block <= 1'b0;
    wait_done("R10 transfer after reset done");

    // R1 defaults restored by chip reset
    resp_sync <= 1'b0;
    @(negedge clk);
    do_reset();
    chk(bus_phase == 3'd0, "R1 phase after second reset", bus_phase, 0);
    set_phase(3'b001);
    pulse_clr();
    push_n(2);
    load(2);
    wait_done("R1 default profile restored");
    chk(req_cnt == 2, "R1 async count after reset", req_cnt, 2);
  endtask

  initial begin
    rst_n = 1'b0; bus_rst = 1'b0; cfg_we = 1'b0; phase_we = 1'b0; len_load = 1'b0;
    cfg_deskew = '0; cfg_timing = '0; cfg_offset = '0; phase_d = '0; len_hi = '0; len_lo = '0;
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", err + mon_err, nchk + mon_chk);
    $finish;
  end
endmodule